// File: doc/BRIEF.md
# Dual PS/2 Port Register Interface

This block sits between a simple single-cycle read/write bus and two byte-level PS/2 link controllers, one for a keyboard and one for a mouse. Each port owns a 256-byte address window: the keyboard window starts at offset 0x000 and the mouse window at offset 0x100. Inside a window only address bits [3:2] pick the register. The link controllers that turn bytes into clock and data wire activity are outside this block. Each one gives the block a received byte, a not-empty flag and an interrupt level. The block gives each one a pop strobe and a transmit strobe with a byte.

Each port has a control byte. Its enable bit is stored and read back but has no other effect. Its loopback bit turns the transmit register into a one-byte local receive buffer. Its diagnostic bit makes the shadow status bits follow the two line-direction bits. The interrupts of both ports are ORed into one output, and each port's status register also reports that merged value.

Each port holds a loopback buffer state machine with two states, `LB_EMPTY` and `LB_FULL`. Reset enters `LB_EMPTY`.
- `LB_EMPTY` moves to `LB_FULL` on a transmit-data write while loopback is set.
- `LB_FULL` moves to `LB_EMPTY` on a receive-data read while loopback is set.
- `LB_FULL` stays in `LB_FULL` on a further loopback write, and the stored byte is replaced.
- In every other case the state holds.

Top module: `ps2_dual_regs`

## Requirements
- R1: After reset, read data is 0x00, `irq_out` is 0, and the control register of both ports reads 0x00.
- R2: Address bit 8 selects the port: 0 is the keyboard and 1 is the mouse. Bits [3:2] select the register: 0 is ID, 1 is receive data, 2 is control, 3 is status. Bits [7:4] and [1:0] are ignored. The ID register reads 0x00 on the keyboard and 0x01 on the mouse.
- R3: A write to register index 2 stores all 8 bits as the control byte. Reading it back returns exactly the byte written. Each port keeps its own control byte. Control bits: bit0 enable, bit1 loopback, bit5 diagnostic, bit6 data direction, bit7 clock direction.
- R4: Writes to register index 0 and index 3 change no state. They produce no link strobe and leave the control and status readings unchanged.
- R5: Status bit6 (data shadow) and status bit7 (clock shadow) read as 1. When control bit5 is set, bit6 reads 0 if control bit6 is 0, and bit7 reads 0 if control bit7 is 0.
- R6: With loopback set, a transmit-data write (index 1) stores the byte and sets status bit0 and the port interrupt. It produces no transmit strobe.
- R7: With loopback set, a receive-data read returns the stored byte, clears status bit0 and clears the port interrupt. It produces no pop strobe.
- R8: With loopback clear, the following hold.
  - A receive-data read returns the link's receive byte and pulses that port's pop strobe for exactly the request cycle.
  - A transmit-data write pulses the transmit strobe for the request cycle, carrying the written byte.
  - Status bit0 equals the link not-empty flag.
- R9: With loopback clear, a port's interrupt equals the link interrupt level sampled at the previous clock edge. `irq_out` is the OR of both port interrupts, and status bit4 of both ports shows that OR.
- R10: Status bits 1, 2, 3 and 5 always read 0.
- R11: Read data is registered. It appears on the clock edge that ends the read request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Request valid for this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address relative to the block base |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_out | output | 1 | Merged interrupt of both ports |
| kbd_rx_data | input | 8 | Keyboard link receive byte |
| kbd_rx_nonempty | input | 1 | Keyboard link has a byte |
| kbd_rx_pop | output | 1 | Keyboard link pop strobe |
| kbd_tx_data | output | 8 | Keyboard transmit byte |
| kbd_tx_strobe | output | 1 | Keyboard transmit strobe |
| kbd_link_irq | input | 1 | Keyboard link interrupt level |
| mse_rx_data | input | 8 | Mouse link receive byte |
| mse_rx_nonempty | input | 1 | Mouse link has a byte |
| mse_rx_pop | output | 1 | Mouse link pop strobe |
| mse_tx_data | output | 8 | Mouse transmit byte |
| mse_tx_strobe | output | 1 | Mouse transmit strobe |
| mse_link_irq | input | 1 | Mouse link interrupt level |

## Verification
The hardest case to reach is a loopback interrupt that hides the link. A port in loopback holds its interrupt even while its link drives the opposite level, and the other port's status register must still show the merged bit. The bench first fills the keyboard loopback buffer while the keyboard link interrupt is low. It then reads the mouse status to see bit4 set through the other window. Finally it drains the buffer and confirms that the merged interrupt falls, with no pop strobe reaching the link.

// File: rtl/ps2r_pkg.sv
package ps2r_pkg;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        REG_ID   = 2'd0,
        REG_DATA = 2'd1,
        REG_CTRL = 2'd2,
        REG_STAT = 2'd3
    } reg_sel_e;

    typedef enum logic {
        LB_EMPTY = 1'b0,
        LB_FULL  = 1'b1
    } lb_state_e;

    localparam int CTL_LOOP   = 1;
    localparam int CTL_DIAG   = 5;
    localparam int CTL_DATDIR = 6;
    localparam int CTL_CLKDIR = 7;

    localparam int ST_RXNE   = 0;
    localparam int ST_IRQ    = 4;
    localparam int ST_DATSHD = 6;
    localparam int ST_CLKSHD = 7;
endpackage

// File: rtl/ps2r_addr_dec.sv
module ps2r_addr_dec
    import ps2r_pkg::*;
#(
    parameter int ADDR_W  = 9,
    parameter int WIN_BIT = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              port_sel,
    output reg_sel_e          reg_sel
);
    always_comb begin
        port_sel = addr[WIN_BIT];
        reg_sel  = reg_sel_e'(addr[3:2]);
    end
endmodule

// File: rtl/ps2r_port.sv
module ps2r_port
    import ps2r_pkg::*;
#(
    parameter logic [DATA_W-1:0] PORT_ID = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic              wr_req,
    input  reg_sel_e          reg_sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              merged_irq,
    output logic [DATA_W-1:0] rd_value,
    output logic [DATA_W-1:0] ctrl_q,
    output logic              lb_full,
    output logic              irq_q,
    input  logic [DATA_W-1:0] link_rx_data,
    input  logic              link_rx_nonempty,
    input  logic              link_irq,
    output logic              link_pop,
    output logic [DATA_W-1:0] link_tx_data,
    output logic              link_tx_strobe
);
    lb_state_e         lb_state, lb_next;
    logic [DATA_W-1:0] lb_buf;
    logic              loop_on;
    logic              lb_wr, lb_rd;

    assign loop_on = ctrl_q[CTL_LOOP];
    assign lb_wr   = wr_req && (reg_sel == REG_DATA) && loop_on;
    assign lb_rd   = rd_req && (reg_sel == REG_DATA) && loop_on;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) lb_state <= LB_EMPTY;
        else        lb_state <= lb_next;
    end

    always_comb begin
        lb_next = lb_state;
        unique case (lb_state)
            LB_EMPTY: if (lb_wr) lb_next = LB_FULL;
            LB_FULL:  if (lb_rd) lb_next = LB_EMPTY;
        endcase
    end

    // control, buffer and interrupt registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            lb_buf <= '0;
            irq_q  <= 1'b0;
        end else begin
            if (wr_req && reg_sel == REG_CTRL) ctrl_q <= wdata;
            if (lb_wr) lb_buf <= wdata;
            if (loop_on) begin
                if (lb_wr)      irq_q <= 1'b1;
                else if (lb_rd) irq_q <= 1'b0;
            end else begin
                irq_q <= link_irq;
            end
        end
    end

    assign lb_full = (lb_state == LB_FULL);

    // outputs
    always_comb begin
        logic [DATA_W-1:0] st;
        st             = '0;
        st[ST_DATSHD]  = !(ctrl_q[CTL_DIAG] && !ctrl_q[CTL_DATDIR]);
        st[ST_CLKSHD]  = !(ctrl_q[CTL_DIAG] && !ctrl_q[CTL_CLKDIR]);
        st[ST_RXNE]    = loop_on ? lb_full : link_rx_nonempty;
        st[ST_IRQ]     = merged_irq;

        unique case (reg_sel)
            REG_ID:   rd_value = PORT_ID;
            REG_DATA: rd_value = loop_on ? lb_buf : link_rx_data;
            REG_CTRL: rd_value = ctrl_q;
            REG_STAT: rd_value = st;
        endcase

        link_pop       = rd_req && (reg_sel == REG_DATA) && !loop_on;
        link_tx_strobe = wr_req && (reg_sel == REG_DATA) && !loop_on;
        link_tx_data   = wdata;
    end
endmodule

// File: rtl/ps2_dual_regs.sv
module ps2_dual_regs
    import ps2r_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              irq_out,
    input  logic [7:0]        kbd_rx_data,
    input  logic              kbd_rx_nonempty,
    output logic              kbd_rx_pop,
    output logic [7:0]        kbd_tx_data,
    output logic              kbd_tx_strobe,
    input  logic              kbd_link_irq,
    input  logic [7:0]        mse_rx_data,
    input  logic              mse_rx_nonempty,
    output logic              mse_rx_pop,
    output logic [7:0]        mse_tx_data,
    output logic              mse_tx_strobe,
    input  logic              mse_link_irq
);
    localparam int NPORT = 2;

    logic                   port_sel;
    reg_sel_e               reg_sel;
    logic [NPORT-1:0][7:0]  p_rd, p_ctrl, p_rx, p_tx;
    logic [NPORT-1:0]       p_lb_full, p_irq, p_rxne, p_lirq, p_pop, p_txs;

    ps2r_addr_dec #(.ADDR_W(ADDR_W), .WIN_BIT(8)) u_dec (
        .addr(bus_addr), .port_sel(port_sel), .reg_sel(reg_sel)
    );

    assign p_rx   = {mse_rx_data, kbd_rx_data};
    assign p_rxne = {mse_rx_nonempty, kbd_rx_nonempty};
    assign p_lirq = {mse_link_irq, kbd_link_irq};
    assign irq_out = |p_irq;

    for (genvar i = 0; i < NPORT; i++) begin : g_port
        logic hit;
        assign hit = bus_valid && (port_sel == 1'(i));
        ps2r_port #(.PORT_ID(8'(i))) u_port (
            .clk(clk), .rst_n(rst_n),
            .rd_req(hit && !bus_write), .wr_req(hit && bus_write),
            .reg_sel(reg_sel), .wdata(bus_wdata), .merged_irq(irq_out),
            .rd_value(p_rd[i]), .ctrl_q(p_ctrl[i]), .lb_full(p_lb_full[i]),
            .irq_q(p_irq[i]),
            .link_rx_data(p_rx[i]), .link_rx_nonempty(p_rxne[i]),
            .link_irq(p_lirq[i]), .link_pop(p_pop[i]),
            .link_tx_data(p_tx[i]), .link_tx_strobe(p_txs[i])
        );
    end

    assign kbd_rx_pop    = p_pop[0];
    assign mse_rx_pop    = p_pop[1];
    assign kbd_tx_data   = p_tx[0];
    assign mse_tx_data   = p_tx[1];
    assign kbd_tx_strobe = p_txs[0];
    assign mse_tx_strobe = p_txs[1];

    always_ff @(posedge clk) begin
        if (!rst_n)                       bus_rdata <= '0;
        else if (bus_valid && !bus_write) bus_rdata <= p_rd[port_sel];
    end
endmodule

// File: rtl/ps2r_checker.sv
module ps2r_checker #(
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_rdata,
    input logic [1:0][7:0]   p_ctrl,
    input logic [1:0]        p_lb_full,
    input logic [1:0]        p_irq,
    input logic [1:0]        p_lirq,
    input logic [1:0]        p_pop,
    input logic [1:0]        p_txs
);
    logic live;
    always_ff @(posedge clk) begin
        if (!rst_n) live <= 1'b0;
        else        live <= 1'b1;
    end

    for (genvar i = 0; i < 2; i++) begin : g_chk
        logic hit_data;
        assign hit_data = bus_valid && bus_addr[8] == 1'(i) && bus_addr[3:2] == 2'd1;

        AST_POP_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
            p_pop[i] |-> (hit_data && !bus_write && !p_ctrl[i][1])); // R8
        AST_TX_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            p_txs[i] |-> (hit_data && bus_write && !p_ctrl[i][1])); // R8
        AST_LB_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_data && bus_write && p_ctrl[i][1]) |=> (p_lb_full[i] && p_irq[i])); // R6
        AST_LB_READ_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_data && !bus_write && p_ctrl[i][1]) |=> (!p_lb_full[i] && !p_irq[i])); // R7
        AST_IRQ_TRACKS_LINK: assert property (@(posedge clk) disable iff (!rst_n)
            (live && !p_ctrl[i][1]) |=> (p_irq[i] == $past(p_lirq[i]))); // R9
    end

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !(bus_valid && !bus_write)) |=> $stable(bus_rdata)); // R11
endmodule

bind ps2_dual_regs ps2r_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .p_ctrl(p_ctrl),
    .p_lb_full(p_lb_full), .p_irq(p_irq), .p_lirq(p_lirq),
    .p_pop(p_pop), .p_txs(p_txs)
);

// File: tb/sim_ps2_dual_regs.sv
`timescale 1ns/1ps
module sim_ps2_dual_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_valid = 1'b0, bus_write = 1'b0;
    logic [8:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_out;
    logic [7:0] kbd_rx_data = '0, mse_rx_data = '0, kbd_tx_data, mse_tx_data;
    logic       kbd_rx_nonempty = 1'b0, mse_rx_nonempty = 1'b0;
    logic       kbd_link_irq = 1'b0, mse_link_irq = 1'b0;
    logic       kbd_rx_pop, mse_rx_pop, kbd_tx_strobe, mse_tx_strobe;

    int n_chk = 0, n_fail = 0;
    int kbd_pops = 0, mse_pops = 0, kbd_txs = 0, mse_txs = 0;
    logic [7:0] last_kbd_tx = '0, last_mse_tx = '0;

    always #5 clk = ~clk;

    ps2_dual_regs u0 (.*);

    always @(posedge clk) begin
        if (kbd_rx_pop) kbd_pops++;
        if (mse_rx_pop) mse_pops++;
        if (kbd_tx_strobe) begin kbd_txs++; last_kbd_tx = kbd_tx_data; end
        if (mse_tx_strobe) begin mse_txs++; last_mse_tx = mse_tx_data; end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 rdata", bus_rdata, 8'h00);
        chk("R1 irq", irq_out, 1'b0);
        rd(9'h008, v); chk("R1 kbd ctrl", v, 8'h00);
        rd(9'h108, v); chk("R1 mse ctrl", v, 8'h00);
    endtask

    task automatic t_id();
        logic [7:0] v;
        rd(9'h000, v); chk("R2 kbd id", v, 8'h00);
        rd(9'h100, v); chk("R2 mse id", v, 8'h01);
        rd(9'h1F3, v); chk("R2 mse id alias", v, 8'h01);
    endtask

    task automatic t_ctrl();
        logic [7:0] v;
        wr(9'h008, 8'hA5);
        wr(9'h1FA, 8'h81);
        rd(9'h008, v); chk("R3 kbd ctrl", v, 8'hA5);
        rd(9'h1F8, v); chk("R3 mse ctrl alias", v, 8'h81);
        wr(9'h008, 8'h00);
        wr(9'h108, 8'h00);
    endtask

    task automatic t_ignored();
        logic [7:0] v;
        int tx0;
        tx0 = kbd_txs;
        wr(9'h000, 8'hFF);
        wr(9'h00C, 8'hFF);
        rd(9'h008, v); chk("R4 ctrl unchanged", v, 8'h00);
        rd(9'h00C, v); chk("R4 status unchanged", v, 8'hC0);
        chk("R4 no strobe", kbd_txs, tx0);
    endtask

    task automatic t_shadow();
        logic [7:0] v;
        wr(9'h108, 8'h20); rd(9'h10C, v); chk("R5 diag dirs 0", v, 8'h00);
        wr(9'h108, 8'h60); rd(9'h10C, v); chk("R5 data dir", v, 8'h40);
        wr(9'h108, 8'hA0); rd(9'h10C, v); chk("R5 clk dir", v, 8'h80);
        wr(9'h108, 8'hC0); rd(9'h10C, v); chk("R5 no diag R10", v, 8'hC0);
        wr(9'h108, 8'h00);
    endtask

    task automatic t_loopback();
        logic [7:0] v;
        int tx0, p0;
        tx0 = kbd_txs; p0 = kbd_pops;
        wr(9'h008, 8'h03);
        wr(9'h004, 8'h5A);
        chk("R6 irq", irq_out, 1'b1);
        chk("R6 no tx", kbd_txs, tx0);
        rd(9'h00C, v); chk("R6 status", v, 8'hD1);
        rd(9'h10C, v); chk("R9 mse sees merged", v, 8'hD0);
        kbd_link_irq = 1'b0;
        rd(9'h004, v); chk("R7 byte", v, 8'h5A);
        chk("R7 irq clear", irq_out, 1'b0);
        chk("R7 no pop", kbd_pops, p0);
        rd(9'h00C, v); chk("R7 status", v, 8'hC0);
        wr(9'h008, 8'h00);
    endtask

    task automatic t_normal();
        logic [7:0] v;
        int p0, t0;
        p0 = mse_pops; t0 = mse_txs;
        mse_rx_data = 8'h3C; mse_rx_nonempty = 1'b1;
        rd(9'h10C, v); chk("R8 rxne", v, 8'hC1);
        rd(9'h104, v); chk("R8 rx byte R11", v, 8'h3C);
        chk("R8 one pop", mse_pops, p0 + 1);
        wr(9'h104, 8'hE7);
        chk("R8 one tx", mse_txs, t0 + 1);
        chk("R8 tx byte", last_mse_tx, 8'hE7);
        mse_rx_nonempty = 1'b0;
    endtask

    task automatic t_irq();
        logic [7:0] v;
        @(negedge clk); kbd_link_irq = 1'b1;
        chk("R9 not yet", irq_out, 1'b0);
        @(negedge clk); chk("R9 follows", irq_out, 1'b1);
        rd(9'h10C, v); chk("R9 mse bit4", v, 8'hD0);
        @(negedge clk); kbd_link_irq = 1'b0;
        @(negedge clk); chk("R9 drops", irq_out, 1'b0);
    endtask

    initial begin : watchdog
        #1000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_id();
        t_ctrl();
        t_ignored();
        t_shadow();
        t_loopback();
        t_normal();
        t_irq();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule